// File: doc/BRIEF.md
# Late-ALU Pipeline Hazard Controller

This block is the forwarding and stall control for a five-stage in-order pipeline. The five stages are fetch, decode, address, execute/memory and writeback. In this pipeline the third stage holds only an adder for load/store effective addresses. Every other instruction passes its operands through that stage untouched. The full ALU sits in the fourth stage, working beside the data memory. A load or store leaves the ALU idle, and an ALU instruction leaves the memory idle.

The controller receives the class and register specifiers of the instruction in decode. It keeps its own copy of the control words for stages 3, 4 and 5. From these it produces:
- a decode stall, which holds the PC and the decode register,
- a flag telling that stage 3 holds an inserted no-op,
- operand bypass selects for stages 3 and 4,
- enables for the stage-3 adder, the stage-4 ALU and the data memory.

Because ALU results appear one stage late, the hazards differ from the usual ones. An ALU result needed as a load/store base register one instruction later forces a one-cycle stall. A loaded value used by the next ALU instruction is forwarded with no stall. Jumps and branches are not handled.

Top module: `late_alu_hazard_ctl`

## Requirements
- R1: While reset is held and right after it is released, with a no-op in decode, every output is 0.
- R2: `stall_id` is 1 in the cycle when decode holds a load (kind 2) or store (kind 3) whose base register `id_srca` equals the destination of an ALU (kind 1) or load in stage 3.
- R3: A stall lasts exactly one cycle while the decode instruction is held. In the following cycle `ac_bubble` is 1 and `stall_id` is 0.
- R4: A load followed directly by an ALU instruction that reads the loaded register does not stall. When that ALU instruction reaches stage 4, its operand select for the matching source is 1.
- R5: `ac_fwd_a`/`ac_fwd_b` are 1 when the stage-3 instruction reads source A (any kind but 0) or source B (ALU or store) and the writeback-stage instruction writes that register.
- R6: `xm_fwd_a` is 1 only for a stage-4 ALU instruction, and `xm_fwd_b` only for a stage-4 ALU or store instruction. Either is set when its source matches the destination written by the writeback-stage instruction.
- R7: Register 0 never causes a stall or a forward.
- R8: Only ALU and load kinds write a register. The destination field of a store or no-op (kind 0) causes no stall and no forward.
- R9: `xm_alu_en` is 1 only for an ALU instruction in stage 4, and `xm_mem_en` only for a load/store there, so the two are never 1 together. `ac_adder_en` is 1 only for a load/store in stage 3.
- R10: An ALU or no-op instruction in decode never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_kind | input | 2 | Decode instruction kind: 0 no-op, 1 ALU, 2 load, 3 store |
| id_dst | input | 5 | Decode destination register |
| id_srca | input | 5 | Decode source A (base register for load/store) |
| id_srcb | input | 5 | Decode source B (store data for stores) |
| stall_id | output | 1 | Hold PC and decode register; stage 3 receives a no-op |
| ac_bubble | output | 1 | Stage 3 holds an inserted no-op |
| ac_fwd_a | output | 1 | Stage-3 source A takes the writeback result |
| ac_fwd_b | output | 1 | Stage-3 source B takes the writeback result |
| xm_fwd_a | output | 1 | Stage-4 source A takes the writeback result |
| xm_fwd_b | output | 1 | Stage-4 source B takes the writeback result |
| ac_adder_en | output | 1 | Stage-3 address adder in use |
| xm_alu_en | output | 1 | Stage-4 ALU in use |
| xm_mem_en | output | 1 | Data memory in use |

## Verification
The controller's only state is the three tracked control words and the bubble flag. A wrong word in stage 3 shows within the same cycle as a wrong or missing `stall_id` for the next load/store, and as a wrong `ac_adder_en`. One cycle later the same word reaches stage 4 and shows in `xm_alu_en`/`xm_mem_en`. One cycle after that it appears as a wrong writeback match in the forward selects. A state error therefore reaches the ports within at most three cycles. The directed sequences place producers at distances one and two from their consumers, so each tracked stage is exposed at least once.

// File: rtl/lah_pkg.sv
package lah_pkg;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned KIND_W = 2;

  typedef logic [RIDX_W-1:0] ridx_t;

  typedef enum logic [KIND_W-1:0] {
    K_NOP   = 2'd0,
    K_ALU   = 2'd1,
    K_LOAD  = 2'd2,
    K_STORE = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e kind;
    ridx_t dst;
    ridx_t srca;
    ridx_t srcb;
  } slot_t;

  localparam slot_t SLOT_EMPTY = '{kind: K_NOP, dst: '0, srca: '0, srcb: '0};

  function automatic logic produces(kind_e k);
    return (k == K_ALU) || (k == K_LOAD);
  endfunction

  function automatic logic is_mem(kind_e k);
    return (k == K_LOAD) || (k == K_STORE);
  endfunction

  function automatic logic uses_a(kind_e k);
    return k != K_NOP;
  endfunction

  function automatic logic uses_b(kind_e k);
    return (k == K_ALU) || (k == K_STORE);
  endfunction

  // producer slot writes the register a consumer names; register 0 never counts
  function automatic logic dep_hit(slot_t prod, ridx_t src);
    return produces(prod.kind) && (prod.dst == src) && (src != '0);
  endfunction
endpackage

// File: rtl/lah_pipe_track.sv
module lah_pipe_track
  import lah_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stall,
  input  slot_t id_slot,
  output slot_t ac_slot,
  output slot_t xm_slot,
  output slot_t wb_slot,
  output logic  ac_bub
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_slot <= SLOT_EMPTY;
      xm_slot <= SLOT_EMPTY;
      wb_slot <= SLOT_EMPTY;
      ac_bub  <= 1'b0;
    end else begin
      ac_slot <= stall ? SLOT_EMPTY : id_slot;
      ac_bub  <= stall;
      xm_slot <= ac_slot;
      wb_slot <= xm_slot;
    end
  end
endmodule

// File: rtl/lah_stall_unit.sv
module lah_stall_unit
  import lah_pkg::*;
(
  input  slot_t id_slot,
  input  slot_t ac_slot,
  output logic  stall
);
  // base register is consumed in stage 3; a stage-3 producer has no result yet
  always_comb begin
    stall = is_mem(id_slot.kind) && dep_hit(ac_slot, id_slot.srca);
  end
endmodule

// File: rtl/lah_fwd_unit.sv
module lah_fwd_unit
  import lah_pkg::*;
#(
  parameter bit LATE_STAGE = 1'b0
)(
  input  slot_t cons,
  input  slot_t prod,
  output logic  fwd_a,
  output logic  fwd_b
);
  logic need_a;
  logic need_b;

  generate
    if (LATE_STAGE) begin : g_late
      // stage 4: only the ALU still reads source A; source B is ALU operand or store data
      assign need_a = (cons.kind == K_ALU);
      assign need_b = uses_b(cons.kind);
    end else begin : g_early
      // stage 3: every operand still travelling toward stage 4
      assign need_a = uses_a(cons.kind);
      assign need_b = uses_b(cons.kind);
    end
  endgenerate

  always_comb begin
    fwd_a = need_a && dep_hit(prod, cons.srca);
    fwd_b = need_b && dep_hit(prod, cons.srcb);
  end
endmodule

// File: rtl/late_alu_hazard_ctl.sv
module late_alu_hazard_ctl
  import lah_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KIND_W-1:0] id_kind,
  input  logic [RIDX_W-1:0] id_dst,
  input  logic [RIDX_W-1:0] id_srca,
  input  logic [RIDX_W-1:0] id_srcb,
  output logic              stall_id,
  output logic              ac_bubble,
  output logic              ac_fwd_a,
  output logic              ac_fwd_b,
  output logic              xm_fwd_a,
  output logic              xm_fwd_b,
  output logic              ac_adder_en,
  output logic              xm_alu_en,
  output logic              xm_mem_en
);
  slot_t id_slot;
  slot_t ac_slot;
  slot_t xm_slot;
  slot_t wb_slot;
  logic  stall_w;
  logic  bub_w;

  // named internal events for the checker
  logic  wb_writes;
  ridx_t wb_dst;

  always_comb begin
    id_slot.kind = kind_e'(id_kind);
    id_slot.dst  = id_dst;
    id_slot.srca = id_srca;
    id_slot.srcb = id_srcb;
  end

  lah_pipe_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (stall_w),
    .id_slot (id_slot),
    .ac_slot (ac_slot),
    .xm_slot (xm_slot),
    .wb_slot (wb_slot),
    .ac_bub  (bub_w)
  );

  lah_stall_unit u_stall (
    .id_slot (id_slot),
    .ac_slot (ac_slot),
    .stall   (stall_w)
  );

  lah_fwd_unit #(.LATE_STAGE(1'b0)) u_fwd_ac (
    .cons  (ac_slot),
    .prod  (wb_slot),
    .fwd_a (ac_fwd_a),
    .fwd_b (ac_fwd_b)
  );

  lah_fwd_unit #(.LATE_STAGE(1'b1)) u_fwd_xm (
    .cons  (xm_slot),
    .prod  (wb_slot),
    .fwd_a (xm_fwd_a),
    .fwd_b (xm_fwd_b)
  );

  assign wb_writes   = produces(wb_slot.kind);
  assign wb_dst      = wb_slot.dst;
  assign stall_id    = stall_w;
  assign ac_bubble   = bub_w;
  assign ac_adder_en = is_mem(ac_slot.kind);
  assign xm_alu_en   = (xm_slot.kind == K_ALU);
  assign xm_mem_en   = is_mem(xm_slot.kind);
endmodule

// File: rtl/lah_checker.sv
module lah_checker
  import lah_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [KIND_W-1:0] id_kind,
  input logic              stall_id,
  input logic              ac_bubble,
  input logic              ac_fwd_a,
  input logic              ac_fwd_b,
  input logic              xm_fwd_a,
  input logic              xm_fwd_b,
  input logic              xm_alu_en,
  input logic              xm_mem_en,
  input logic              wb_writes,
  input logic [RIDX_W-1:0] wb_dst
);
  // R3
  stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_id |=> !stall_id);

  // R3
  bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_id |=> ac_bubble);

  // R9
  unit_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xm_alu_en && xm_mem_en));

  // R7
  fwd_source_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_fwd_a || ac_fwd_b || xm_fwd_a || xm_fwd_b) |-> (wb_writes && (wb_dst != '0)));

  // R10
  stall_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_id |-> (id_kind == 2'd2 || id_kind == 2'd3));
endmodule

bind late_alu_hazard_ctl lah_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .id_kind   (id_kind),
  .stall_id  (stall_id),
  .ac_bubble (ac_bubble),
  .ac_fwd_a  (ac_fwd_a),
  .ac_fwd_b  (ac_fwd_b),
  .xm_fwd_a  (xm_fwd_a),
  .xm_fwd_b  (xm_fwd_b),
  .xm_alu_en (xm_alu_en),
  .xm_mem_en (xm_mem_en),
  .wb_writes (wb_writes),
  .wb_dst    (wb_dst)
);

// File: tb/late_alu_hazard_ctl_test.sv
module late_alu_hazard_ctl_test;
  localparam logic [1:0] NOP = 2'd0, ALU = 2'd1, LD = 2'd2, ST = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] id_kind = NOP;
  logic [4:0] id_dst = '0, id_srca = '0, id_srcb = '0;
  logic stall_id, ac_bubble, ac_fwd_a, ac_fwd_b, xm_fwd_a, xm_fwd_b;
  logic ac_adder_en, xm_alu_en, xm_mem_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  late_alu_hazard_ctl uut (
    .clk(clk), .rst_n(rst_n), .id_kind(id_kind), .id_dst(id_dst),
    .id_srca(id_srca), .id_srcb(id_srcb), .stall_id(stall_id),
    .ac_bubble(ac_bubble), .ac_fwd_a(ac_fwd_a), .ac_fwd_b(ac_fwd_b),
    .xm_fwd_a(xm_fwd_a), .xm_fwd_b(xm_fwd_b), .ac_adder_en(ac_adder_en),
    .xm_alu_en(xm_alu_en), .xm_mem_en(xm_mem_en)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // present one instruction in decode for one cycle, then sample mid-cycle
  task automatic drive(input logic [1:0] k, input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
    @(negedge clk);
    id_kind = k; id_dst = d; id_srca = a; id_srcb = b;
    #5;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) drive(NOP, 0, 0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "ac_bubble in reset", ac_bubble, 1'b0);
    chk("R1", "stall in reset", stall_id, 1'b0);
    rst_n = 1'b1;
    drive(NOP, 0, 0, 0);
    chk("R1", "outputs after reset",
        stall_id | ac_bubble | ac_fwd_a | ac_fwd_b | xm_fwd_a | xm_fwd_b |
        ac_adder_en | xm_alu_en | xm_mem_en, 1'b0);
  endtask

  task automatic t_alu_to_base();
    flush();
    drive(ALU, 1, 2, 3);
    chk("R2", "no stall for ALU", stall_id, 1'b0);
    drive(LD, 4, 1, 0);
    chk("R2", "stall ALU->load base", stall_id, 1'b1);
    drive(LD, 4, 1, 0);
    chk("R3", "stall ends", stall_id, 1'b0);
    chk("R3", "bubble in stage 3", ac_bubble, 1'b1);
    chk("R9", "ALU enabled in stage 4", xm_alu_en, 1'b1);
    chk("R9", "memory idle for ALU", xm_mem_en, 1'b0);
    chk("R9", "adder idle on bubble", ac_adder_en, 1'b0);
    drive(NOP, 0, 0, 0);
    chk("R5", "stage-3 base forward", ac_fwd_a, 1'b1);
    chk("R9", "adder on for load", ac_adder_en, 1'b1);
    chk("R3", "bubble gone", ac_bubble, 1'b0);
    drive(NOP, 0, 0, 0);
    chk("R9", "memory on for load", xm_mem_en, 1'b1);
    chk("R9", "ALU idle for load", xm_alu_en, 1'b0);
  endtask

  task automatic t_load_to_alu();
    flush();
    drive(LD, 2, 5, 0);
    drive(ALU, 6, 7, 2);
    chk("R4", "no stall load->ALU", stall_id, 1'b0);
    drive(NOP, 0, 0, 0);
    chk("R4", "no stage-3 forward yet", ac_fwd_b, 1'b0);
    drive(NOP, 0, 0, 0);
    chk("R4", "stage-4 B forward from load", xm_fwd_b, 1'b1);
    chk("R4", "stage-4 A untouched", xm_fwd_a, 1'b0);
  endtask

  task automatic t_distance_two();
    flush();
    drive(ALU, 3, 1, 1);
    drive(NOP, 0, 0, 0);
    drive(ALU, 8, 3, 0);
    chk("R10", "ALU consumer no stall", stall_id, 1'b0);
    drive(NOP, 0, 0, 0);
    chk("R5", "stage-3 A forward distance 2", ac_fwd_a, 1'b1);
    chk("R5", "stage-3 B no match", ac_fwd_b, 1'b0);
    drive(NOP, 0, 0, 0);
    chk("R6", "stage-4 A no forward from no-op", xm_fwd_a, 1'b0);
  endtask

  task automatic t_reg_zero();
    flush();
    drive(ALU, 0, 1, 2);
    drive(LD, 4, 0, 0);
    chk("R7", "no stall on r0 base", stall_id, 1'b0);
    flush();
    drive(ALU, 0, 1, 2);
    drive(ALU, 5, 0, 0);
    drive(NOP, 0, 0, 0);
    drive(NOP, 0, 0, 0);
    chk("R7", "no stage-4 A forward r0", xm_fwd_a, 1'b0);
    chk("R7", "no stage-4 B forward r0", xm_fwd_b, 1'b0);
  endtask

  task automatic t_store();
    flush();
    drive(ALU, 5, 1, 1);
    drive(ST, 0, 6, 5);
    chk("R6", "no stall on store data", stall_id, 1'b0);
    drive(NOP, 0, 0, 0);
    drive(NOP, 0, 0, 0);
    chk("R6", "store data forward", xm_fwd_b, 1'b1);
    chk("R6", "store base not forwarded in stage 4", xm_fwd_a, 1'b0);
    flush();
    drive(LD, 7, 1, 0);
    drive(ST, 0, 7, 9);
    chk("R2", "stall load->store base", stall_id, 1'b1);
    drive(ST, 0, 7, 9);
    chk("R3", "store stall single cycle", stall_id, 1'b0);
  endtask

  task automatic t_non_writers();
    flush();
    drive(ST, 8, 1, 2);
    drive(LD, 4, 8, 0);
    chk("R8", "store dst ignored", stall_id, 1'b0);
    flush();
    drive(NOP, 9, 0, 0);
    drive(ALU, 1, 9, 9);
    drive(NOP, 0, 0, 0);
    drive(NOP, 0, 0, 0);
    chk("R8", "no-op dst ignored A", xm_fwd_a, 1'b0);
    chk("R8", "no-op dst ignored B", xm_fwd_b, 1'b0);
  endtask

  task automatic t_alu_consumers();
    flush();
    drive(LD, 3, 1, 0);
    drive(ALU, 4, 3, 3);
    chk("R10", "ALU after load no stall", stall_id, 1'b0);
    flush();
    drive(ALU, 3, 1, 1);
    drive(ALU, 4, 3, 3);
    chk("R10", "ALU after ALU no stall", stall_id, 1'b0);
    drive(NOP, 0, 0, 0);
    drive(NOP, 0, 0, 0);
    chk("R6", "stage-4 A forward ALU->ALU", xm_fwd_a, 1'b1);
    chk("R6", "stage-4 B forward ALU->ALU", xm_fwd_b, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_alu_to_base();
    t_load_to_alu();
    t_distance_two();
    t_reg_zero();
    t_store();
    t_non_writers();
    t_alu_consumers();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule